// File: doc/BRIEF.md
# SPI Mode-0 Target Byte Front End

This block is the serial edge of an SPI target that runs from a fast system clock. It passes the serial clock, the active-low select and the host data line through two-flop synchronisers, finds their edges, and gathers the host bits, most significant first, into bytes. Each finished byte is presented for one system cycle with a valid strobe. The block also emits single-cycle events when select falls and when it rises. It does not interpret the byte stream. Decoding commands, register access and framing phases are the job of the layer above.

On the return path the block asks the upper layer for a byte with a request pulse. This happens when select falls and again at every byte boundary. The upper layer answers in that same cycle with a byte and a valid flag. If the flag is low, the block sends the fixed idle marker 0xF0 instead. The first bit of a frame appears as soon as select falls. Each later bit changes on a falling serial clock edge. The output enable is asserted only while select is low, so an external pad can tri-state the line on a shared bus. The system clock must run at least four times faster than the serial clock.

Top module: `spi_tgt_byte_if`

## Requirements
- R1: The serial clock idles low. Host data is sampled on a rising serial clock edge. The outgoing bit (`miso_o`) changes only on a falling serial clock edge or a select edge, and it holds steady across each rising edge.
- R2: Bytes are 8 bits wide and the most significant bit arrives first. After the eighth rising edge of a byte, `rx_valid_o` is high for exactly one system cycle, and `rx_byte_o` holds the received byte in that cycle.
- R3: `miso_oe_o` is 1 only while the synchronised select is low. It returns to 0 within one system cycle after select rises.
- R4: Bit 7 of a frame's first outgoing byte is on `miso_o` after select falls and before the first serial clock edge.
- R5: When select rises in the middle of a byte, that partial byte is dropped and `rx_valid_o` does not pulse for it.
- R6: If `tx_valid_i` is 0 when a byte is taken, the byte sent is 0xF0.
- R7: `cs_fall_o` and `cs_rise_o` each pulse for exactly one system cycle per select edge.
- R8: The bit counter restarts at every select fall. A frame that follows an aborted partial byte therefore receives its first full byte correctly.
- R9: `tx_req_o` pulses once at the select fall and once at each byte boundary. The byte on `tx_byte_i` in that cycle becomes the next byte sent, and its bit 7 goes out on the following falling serial clock edge.
- R10: While reset is active, `miso_oe_o`, `miso_o`, `rx_valid_o` and `tx_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from host, idle low |
| cs_ni | input | 1 | Active-low select from host |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the external tri-state pad |
| rx_valid_o | output | 1 | One-cycle strobe marking a completed received byte |
| rx_byte_o | output | 8 | Received byte, valid with rx_valid_o |
| tx_req_o | output | 1 | Request for the next byte to send |
| tx_valid_i | input | 1 | Upper layer has a defined byte for this request |
| tx_byte_i | input | 8 | Byte to send, sampled while tx_req_o is high |
| cs_fall_o | output | 1 | One-cycle event when select becomes active |
| cs_rise_o | output | 1 | One-cycle event when select becomes inactive |

## Verification
The hardest case to reach from the ports is a frame that is cut off partway through a byte, followed directly by a new frame. In that case, stale counter state would shift every later byte. The stimulus produces it by clocking three bits, raising select, and then running a full frame whose byte must come back exactly. It checks that no strobe appeared for the dropped bits.

The byte-boundary handoff is the other hard case. The next transmit byte is taken at the eighth rising edge but must not appear until the following falling edge. The bench changes its offered byte just before that eighth edge. It then checks the line both before and after every rising edge, walking a table of frames that mix defined bytes with idle-filled ones.

// File: rtl/spi_tgt_pkg.sv
`timescale 1ns/1ps
package spi_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] IDLE_FILL = 8'hF0;

  typedef logic [BYTE_W-1:0] byte_t;

  // Byte actually sent for a request: defined data or the idle marker.
  function automatic byte_t pick_tx(input logic vld, input byte_t data);
    return vld ? data : IDLE_FILL;
  endfunction

  // Shift one new bit in at the LSB end (MSB-first reception).
  function automatic byte_t shift_in(input byte_t cur, input logic bit_in);
    return {cur[BYTE_W-2:0], bit_in};
  endfunction
endpackage

// File: rtl/spi_tgt_sync.sv
`timescale 1ns/1ps
module spi_tgt_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= RST_VAL;
        else         pipe[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= RST_VAL;
        else         pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_tgt_edges.sv
`timescale 1ns/1ps
module spi_tgt_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic cs_s_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_active_o
);
  logic sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      cs_q  <= cs_s_i;
    end
  end

  assign sck_rise_o  =  sck_s_i & ~sck_q;
  assign sck_fall_o  = ~sck_s_i &  sck_q;
  assign cs_fall_o   = ~cs_s_i  &  cs_q;
  assign cs_rise_o   =  cs_s_i  & ~cs_q;
  assign cs_active_o = ~cs_s_i;

  AST_CS_FALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_o |=> !cs_fall_o); // R7
  AST_CS_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_o |=> !cs_rise_o); // R7
endmodule

// File: rtl/spi_tgt_rx.sv
`timescale 1ns/1ps
module spi_tgt_rx
  import spi_tgt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sck_rise_i,
  input  logic  cs_fall_i,
  input  logic  cs_active_i,
  input  logic  mosi_s_i,
  output logic  byte_done_o,
  output logic  rx_valid_o,
  output byte_t rx_byte_o
);
  logic [CNT_W-1:0] bit_cnt;
  byte_t            shreg;

  assign byte_done_o = sck_rise_i & cs_active_i & (bit_cnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      rx_valid_o <= byte_done_o;
      if (byte_done_o) rx_byte_o <= shift_in(shreg, mosi_s_i);
      if (cs_fall_i || !cs_active_i) begin
        bit_cnt <= '0;
      end else if (sck_rise_i) begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= shift_in(shreg, mosi_s_i);
      end
    end
  end

  AST_RX_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(sck_rise_i)); // R2
  AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R2
  AST_NO_BYTE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active_i |-> !byte_done_o); // R5
endmodule

// File: rtl/spi_tgt_tx.sv
`timescale 1ns/1ps
module spi_tgt_tx
  import spi_tgt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_fall_i,
  input  logic  cs_rise_i,
  input  logic  cs_active_i,
  input  logic  sck_fall_i,
  input  logic  byte_done_i,
  input  logic  tx_valid_i,
  input  byte_t tx_byte_i,
  output logic  tx_req_o,
  output logic  miso_o,
  output logic  miso_oe_o
);
  byte_t tx_sh, tx_nxt;
  logic  pend;

  assign tx_req_o = cs_fall_i | byte_done_i;
  assign miso_o   = miso_oe_o & tx_sh[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh     <= '0;
      tx_nxt    <= '0;
      pend      <= 1'b0;
      miso_oe_o <= 1'b0;
    end else if (cs_fall_i) begin
      tx_sh     <= pick_tx(tx_valid_i, tx_byte_i);
      pend      <= 1'b0;
      miso_oe_o <= 1'b1;
    end else if (cs_rise_i) begin
      pend      <= 1'b0;
      miso_oe_o <= 1'b0;
    end else begin
      if (byte_done_i) begin
        tx_nxt <= pick_tx(tx_valid_i, tx_byte_i);
        pend   <= 1'b1;
      end
      if (sck_fall_i && cs_active_i) begin
        if (pend) begin
          tx_sh <= tx_nxt;
          pend  <= 1'b0;
        end else begin
          tx_sh <= tx_sh << 1;
        end
      end
    end
  end

  AST_OE_ONLY_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_active_i && !cs_rise_i) |-> !miso_oe_o); // R3
  AST_MISO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall_i && !cs_fall_i && !cs_rise_i) |=> $stable(miso_o)); // R1
endmodule

// File: rtl/spi_tgt_byte_if.sv
`timescale 1ns/1ps
module spi_tgt_byte_if
  import spi_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       tx_req_o,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_byte_i,
  output logic       cs_fall_o,
  output logic       cs_rise_o
);
  // Synchronised pin bundle: {sck, cs, mosi}
  logic [2:0] pins_s;
  logic       sck_rise, sck_fall, cs_active, byte_done;

  spi_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i}),
    .q_o   (pins_s)
  );

  spi_tgt_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (pins_s[2]),
    .cs_s_i     (pins_s[1]),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .cs_fall_o  (cs_fall_o),
    .cs_rise_o  (cs_rise_o),
    .cs_active_o(cs_active)
  );

  spi_tgt_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_rise_i (sck_rise),
    .cs_fall_i  (cs_fall_o),
    .cs_active_i(cs_active),
    .mosi_s_i   (pins_s[0]),
    .byte_done_o(byte_done),
    .rx_valid_o (rx_valid_o),
    .rx_byte_o  (rx_byte_o)
  );

  spi_tgt_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (cs_fall_o),
    .cs_rise_i  (cs_rise_o),
    .cs_active_i(cs_active),
    .sck_fall_i (sck_fall),
    .byte_done_i(byte_done),
    .tx_valid_i (tx_valid_i),
    .tx_byte_i  (tx_byte_i),
    .tx_req_o   (tx_req_o),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o)
  );

  AST_REQ_BEFORE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(tx_req_o)); // R9
endmodule

// File: tb/spi_tgt_byte_if_tb.sv
`timescale 1ns/1ps
module spi_tgt_byte_if_tb;
  localparam int HALF = 4;              // system cycles per serial half-period
  localparam logic [7:0] FILL = 8'hF0;
  localparam int NV = 6;
  // {mosi byte, offered tx byte, tx valid}
  localparam logic [16:0] VEC [NV] = '{
    {8'h3C, 8'hA7, 1'b1},
    {8'hFF, 8'h00, 1'b1},
    {8'h00, 8'h5A, 1'b0},
    {8'h81, 8'hFF, 1'b1},
    {8'h6D, 8'h12, 1'b0},
    {8'hC3, 8'h96, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic tx_vld = 1'b0;
  logic [7:0] tx_b = 8'h00;
  logic miso_o, miso_oe_o, rx_valid_o, tx_req_o, cs_fall_o, cs_rise_o;
  logic [7:0] rx_byte_o;

  int checks = 0, errors = 0;
  int rx_n = 0, n_cf = 0, n_cr = 0, n_req = 0;
  logic [7:0] got [16];

  always #2.5 clk = ~clk;

  spi_tgt_byte_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .rx_valid_o(rx_valid_o),
    .rx_byte_o(rx_byte_o), .tx_req_o(tx_req_o), .tx_valid_i(tx_vld),
    .tx_byte_i(tx_b), .cs_fall_o(cs_fall_o), .cs_rise_o(cs_rise_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid_o) begin
        got[rx_n % 16] = rx_byte_o;
        rx_n++;
      end
      if (cs_fall_o) n_cf++;
      if (cs_rise_o) n_cr++;
      if (tx_req_o)  n_req++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One byte: check each outgoing bit before and after its rising edge.
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_m,
                      input logic [7:0] nb, input logic nv, input string tag);
    for (int b = 7; b >= 0; b--) begin
      mosi = mo[b];
      cyc(HALF);
      chk(tag, {15'd0, miso_o}, {15'd0, exp_m[b]});
      if (b == 0) begin tx_b = nb; tx_vld = nv; end
      sck = 1'b1;
      cyc(HALF);
      chk("R1 stable across rise", {15'd0, miso_o}, {15'd0, exp_m[b]});
      sck = 1'b0;
    end
  endtask

  initial begin
    int rx0, cf0, cr0, rq0;
    cyc(3);
    // R10 reset state
    chk("R10 oe", {15'd0, miso_oe_o}, 16'd0);
    chk("R10 miso", {15'd0, miso_o}, 16'd0);
    chk("R10 rx_valid", {15'd0, rx_valid_o}, 16'd0);
    chk("R10 tx_req", {15'd0, tx_req_o}, 16'd0);
    rst_n = 1'b1;
    cyc(6);

    // Table-driven frame
    rx0 = rx_n; cf0 = n_cf; cr0 = n_cr; rq0 = n_req;
    tx_b = VEC[0][8:1]; tx_vld = VEC[0][0];
    cs_n = 1'b0;
    cyc(HALF);
    chk("R3 oe in frame", {15'd0, miso_oe_o}, 16'd1);
    for (int i = 0; i < NV; i++) begin
      logic [7:0] em;
      em = VEC[i][0] ? VEC[i][8:1] : FILL;
      if (i + 1 < NV)
        xfer(VEC[i][16:9], em, VEC[i+1][8:1], VEC[i+1][0],
             i == 0 ? "R4 first bit" : (VEC[i][0] ? "R9 handoff" : "R6 fill"));
      else
        xfer(VEC[i][16:9], em, 8'h00, 1'b0, VEC[i][0] ? "R9 handoff" : "R6 fill");
    end
    cyc(HALF);
    cs_n = 1'b1;
    cyc(6);
    chk("R3 oe after frame", {15'd0, miso_oe_o}, 16'd0);
    chk("R2 byte count", 16'(rx_n - rx0), 16'(NV));
    for (int i = 0; i < NV; i++)
      chk("R2 rx byte", {8'd0, got[(rx0 + i) % 16]}, {8'd0, VEC[i][16:9]});
    chk("R7 cs_fall count", 16'(n_cf - cf0), 16'd1);
    chk("R7 cs_rise count", 16'(n_cr - cr0), 16'd1);
    chk("R9 tx_req count", 16'(n_req - rq0), 16'(NV + 1));

    // Aborted partial byte, then a fresh frame
    rx0 = rx_n;
    tx_b = 8'h00; tx_vld = 1'b0;
    cs_n = 1'b0;
    for (int b = 0; b < 3; b++) begin
      mosi = b[0]; cyc(HALF); sck = 1'b1; cyc(HALF); sck = 1'b0;
    end
    cyc(HALF);
    cs_n = 1'b1;
    cyc(8);
    chk("R5 partial dropped", 16'(rx_n - rx0), 16'd0);
    chk("R3 oe idle", {15'd0, miso_oe_o}, 16'd0);

    rx0 = rx_n;
    tx_b = 8'h5C; tx_vld = 1'b1;
    cs_n = 1'b0;
    xfer(8'hA5, 8'h5C, 8'h00, 1'b0, "R4 first bit after abort");
    cyc(HALF);
    cs_n = 1'b1;
    cyc(6);
    chk("R8 realigned count", 16'(rx_n - rx0), 16'd1);
    chk("R8 realigned byte", {8'd0, got[rx0 % 16]}, 16'h00A5);

    // Undefined first byte is the idle marker
    tx_vld = 1'b0; tx_b = 8'h3E;
    cs_n = 1'b0;
    xfer(8'h0F, FILL, 8'h00, 1'b0, "R6 fill first");
    cyc(HALF);
    cs_n = 1'b1;
    cyc(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule